// File: doc/BRIEF.md
# Time-Multiplexed Width-Adapting Router Port

This block joins a wide, slow module interface to a narrow, fast network link. The link carries 150-bit flits, and the module side moves 600-bit words, four flits each. One fast clock drives the whole block. An internal phase counter produces a strobe on one fast cycle in every four. That strobe marks the slow-side cycle in which the module hands over a word or receives one.

Toward the network, an accepted word is cut into four flits. They leave on consecutive fast cycles, lowest slice first, and every flit carries a 2-bit virtual-channel tag. If the link withholds ready, the current flit is held and the sequence stops. The port also has a single-slot mode for modules that need only one flit's width. In that mode the module's word occupies one chosen position of the four-step frame, and the other three positions stay idle.

Toward the module, incoming flits are collected into a wide word. The word is handed over at the next strobe and then held for one slow period. In single-slot mode every incoming flit forms a word of its own.

Top module: `tdm_router_port`

## Requirements
- R1: `slow_tick` is high on exactly one fast cycle in every four. Counting the first cycle with reset low as cycle 0, it is high in cycles 3, 7, 11 and so on.
- R2: `mod_in_ready` is high only in a `slow_tick` cycle, and only when the serializer is idle or is taking its final step in that cycle.
- R3: In full mode (`cfg_single`=0), a word accepted in cycle t appears on the link in cycles t+1 to t+4. The flit in step k (k = 0..3) is bits [150k+149:150k] of the word, and every flit carries the word's `mod_in_vc`.
- R4: While `lnk_out_valid` is high and `lnk_out_ready` is low, the next cycle shows the same flit and VC with valid still high. The step sequence resumes after the handshake, and no flit is lost.
- R5: In single-slot mode (`cfg_single`=1), `lnk_out_valid` is high only in step `cfg_slot`, where step 0 is the cycle after acceptance. That flit is bits [149:0] of the word. The other steps are idle and advance without needing ready. The mode and slot are captured when the word is accepted.
- R6: With the link ready, a new word can be accepted in the same strobe cycle that sends the previous word's final step, so words follow one another with no gap.
- R7: On the module-receive path in full mode, four accepted flits form one word. The first flit becomes bits [149:0] and the fourth becomes bits [599:450]. `mod_out_vc` is the VC of the first flit.
- R8: `mod_out_valid`, `mod_out_data` and `mod_out_vc` change only on the cycle after a `slow_tick`. A word completed before a strobe is presented for the four cycles after that strobe. If no word was complete at the strobe, `mod_out_valid` is low for the next four cycles.
- R9: Once a word has been completed on the receive path, `lnk_in_ready` stays low until the strobe that moves the word to the output.
- R10: On the receive path in single-slot mode, each accepted flit completes a word. The flit becomes bits [149:0], the upper bits are zero, and the word carries that flit's VC.
- R11: After reset, `lnk_out_valid`, `mod_out_valid` and `mod_in_ready` are low and `lnk_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single | input | 1 | 1 selects single-slot mode, 0 selects full four-flit mode |
| cfg_slot | input | 2 | Frame step that carries the flit in single-slot mode |
| slow_tick | output | 1 | Slow-phase strobe, one cycle in four |
| mod_in_valid | input | 1 | Module word offered |
| mod_in_ready | output | 1 | Word taken in this cycle if valid |
| mod_in_data | input | 600 | Wide word from the module |
| mod_in_vc | input | 2 | Virtual channel for the word's flits |
| lnk_out_valid | output | 1 | Flit offered to the router |
| lnk_out_ready | input | 1 | Router accepts the flit |
| lnk_out_flit | output | 150 | Outgoing flit |
| lnk_out_vc | output | 2 | Outgoing flit's virtual channel |
| lnk_in_valid | input | 1 | Flit offered by the router |
| lnk_in_ready | output | 1 | Port accepts the flit |
| lnk_in_flit | input | 150 | Incoming flit |
| lnk_in_vc | input | 2 | Incoming flit's virtual channel |
| mod_out_valid | output | 1 | Wide word presented to the module |
| mod_out_data | output | 600 | Reassembled wide word |
| mod_out_vc | output | 2 | VC of the word's first flit |

## Verification
Both `mod_in_ready` and the strobe are combinational from registers, so the bench reads them on the same falling edge where it offers a word. The flit for step k is due k+1 cycles after the accepting edge, and the bench samples it at the falling edge of that cycle. On the receive path, the bench first waits for the strobe that follows the fourth accepted flit and checks that `lnk_in_ready` is low there. One cycle later it expects the word on the output and checks that it stays for four falling edges. Stall windows are counted in whole cycles, and the held flit is compared on each falling edge inside the window.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int FLIT_BITS  = 150;
    localparam int SLOT_COUNT = 4;
    localparam int VC_COUNT   = 4;

    typedef enum logic {
        MODE_FULL   = 1'b0,
        MODE_SINGLE = 1'b1
    } slot_mode_e;

    // Width of a counter that indexes n positions (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen
    import tdm_port_pkg::*;
#(
    parameter int SLOTS = SLOT_COUNT
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = idx_bits(SLOTS);
    localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_port_pkg::*;
#(
    parameter int FLIT_W = FLIT_BITS,
    parameter int SLOTS  = SLOT_COUNT,
    parameter int VC_W   = 2,
    localparam int SW     = idx_bits(SLOTS),
    localparam int WORD_W = FLIT_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  slot_mode_e        mode,
    input  logic [SW-1:0]     slot_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [VC_W-1:0]   in_vc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLIT_W-1:0] out_flit,
    output logic [VC_W-1:0]   out_vc
);
    localparam logic [SW-1:0] LAST_STEP = SW'(SLOTS - 1);

    logic [WORD_W-1:0] word_q;
    logic [VC_W-1:0]   vc_q;
    logic [SW-1:0]     step_q;
    logic [SW-1:0]     slot_q;
    slot_mode_e        mode_q;
    logic              busy_q;

    logic [FLIT_W-1:0] lane [SLOTS];
    logic              slot_live;
    logic              advance;
    logic              at_last;
    logic              take;

    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        assign lane[g] = word_q[g*FLIT_W +: FLIT_W];
    end

    always_comb begin
        slot_live = (mode_q == MODE_FULL) || (step_q == slot_q);
        out_valid = busy_q && slot_live;
        out_flit  = (mode_q == MODE_SINGLE) ? lane[0] : lane[step_q];
        out_vc    = vc_q;
        advance   = busy_q && (!slot_live || out_ready);
        at_last   = (step_q == LAST_STEP);
        in_ready  = tick && (!busy_q || (at_last && advance));
        take      = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vc_q   <= '0;
            step_q <= '0;
            slot_q <= '0;
            mode_q <= MODE_FULL;
            busy_q <= 1'b0;
        end else if (take) begin
            word_q <= in_word;
            vc_q   <= in_vc;
            mode_q <= mode;
            slot_q <= slot_sel;
            step_q <= '0;
            busy_q <= 1'b1;
        end else if (advance) begin
            if (at_last) begin
                step_q <= '0;
                busy_q <= 1'b0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_deserializer.sv
module tdm_deserializer
    import tdm_port_pkg::*;
#(
    parameter int FLIT_W = FLIT_BITS,
    parameter int SLOTS  = SLOT_COUNT,
    parameter int VC_W   = 2,
    localparam int SW     = idx_bits(SLOTS),
    localparam int WORD_W = FLIT_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  slot_mode_e        mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic [VC_W-1:0]   in_vc,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [VC_W-1:0]   out_vc
);
    localparam logic [SW-1:0] LAST_CNT = SW'(SLOTS - 1);

    logic [FLIT_W-1:0] lane_q [SLOTS];
    logic [WORD_W-1:0] gathered;
    logic [SW-1:0]     cnt_q;
    logic [VC_W-1:0]   vc_q;
    logic              done_q;
    logic              take;
    logic              closes;

    assign in_ready = !done_q;
    assign take     = in_valid && !done_q;
    assign closes   = take && ((mode == MODE_SINGLE) || (cnt_q == LAST_CNT));

    for (genvar g = 0; g < SLOTS; g++) begin : g_gather
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (take) begin
                if (mode == MODE_SINGLE) begin
                    lane_q[g] <= (g == 0) ? in_flit : '0;
                end else if (cnt_q == SW'(g)) begin
                    lane_q[g] <= in_flit;
                end
            end
        end
        assign gathered[g*FLIT_W +: FLIT_W] = lane_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            vc_q      <= '0;
            done_q    <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
            out_vc    <= '0;
        end else begin
            if (take) begin
                if ((cnt_q == '0) || (mode == MODE_SINGLE)) begin
                    vc_q <= in_vc;
                end
                cnt_q <= closes ? '0 : cnt_q + 1'b1;
            end
            if (closes) begin
                done_q <= 1'b1;
            end else if (tick) begin
                done_q <= 1'b0;
            end
            if (tick) begin
                out_valid <= done_q;
                if (done_q) begin
                    out_word <= gathered;
                    out_vc   <= vc_q;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_router_port.sv
module tdm_router_port
    import tdm_port_pkg::*;
#(
    parameter int FLIT_W   = FLIT_BITS,
    parameter int SLOTS    = SLOT_COUNT,
    parameter int VC_COUNT = tdm_port_pkg::VC_COUNT,
    localparam int VC_W   = idx_bits(VC_COUNT),
    localparam int SW     = idx_bits(SLOTS),
    localparam int WORD_W = FLIT_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_single,
    input  logic [SW-1:0]     cfg_slot,
    output logic              slow_tick,
    input  logic              mod_in_valid,
    output logic              mod_in_ready,
    input  logic [WORD_W-1:0] mod_in_data,
    input  logic [VC_W-1:0]   mod_in_vc,
    output logic              lnk_out_valid,
    input  logic              lnk_out_ready,
    output logic [FLIT_W-1:0] lnk_out_flit,
    output logic [VC_W-1:0]   lnk_out_vc,
    input  logic              lnk_in_valid,
    output logic              lnk_in_ready,
    input  logic [FLIT_W-1:0] lnk_in_flit,
    input  logic [VC_W-1:0]   lnk_in_vc,
    output logic              mod_out_valid,
    output logic [WORD_W-1:0] mod_out_data,
    output logic [VC_W-1:0]   mod_out_vc
);
    slot_mode_e mode;
    assign mode = cfg_single ? MODE_SINGLE : MODE_FULL;

    tdm_phase_gen #(.SLOTS(SLOTS)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick)
    );

    tdm_serializer #(.FLIT_W(FLIT_W), .SLOTS(SLOTS), .VC_W(VC_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .tick      (slow_tick),
        .mode      (mode),
        .slot_sel  (cfg_slot),
        .in_valid  (mod_in_valid),
        .in_ready  (mod_in_ready),
        .in_word   (mod_in_data),
        .in_vc     (mod_in_vc),
        .out_valid (lnk_out_valid),
        .out_ready (lnk_out_ready),
        .out_flit  (lnk_out_flit),
        .out_vc    (lnk_out_vc)
    );

    tdm_deserializer #(.FLIT_W(FLIT_W), .SLOTS(SLOTS), .VC_W(VC_W)) u_des (
        .clk       (clk),
        .rst       (rst),
        .tick      (slow_tick),
        .mode      (mode),
        .in_valid  (lnk_in_valid),
        .in_ready  (lnk_in_ready),
        .in_flit   (lnk_in_flit),
        .in_vc     (lnk_in_vc),
        .out_valid (mod_out_valid),
        .out_word  (mod_out_data),
        .out_vc    (mod_out_vc)
    );
endmodule

// File: rtl/tdm_router_port_chk.sv
module tdm_router_port_chk
    import tdm_port_pkg::*;
#(
    parameter int FLIT_W   = FLIT_BITS,
    parameter int SLOTS    = SLOT_COUNT,
    parameter int VC_COUNT = tdm_port_pkg::VC_COUNT,
    localparam int VC_W   = idx_bits(VC_COUNT),
    localparam int WORD_W = FLIT_W * SLOTS
) (
    input logic              clk,
    input logic              rst,
    input logic              slow_tick,
    input logic              mod_in_ready,
    input logic              lnk_out_valid,
    input logic              lnk_out_ready,
    input logic [FLIT_W-1:0] lnk_out_flit,
    input logic [VC_W-1:0]   lnk_out_vc,
    input logic              lnk_in_ready,
    input logic              mod_out_valid,
    input logic [WORD_W-1:0] mod_out_data
);
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !slow_tick);

    assert_accept_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        mod_in_ready |-> slow_tick);

    assert_hold_flit_R4: assert property (@(posedge clk) disable iff (rst)
        (lnk_out_valid && !lnk_out_ready) |=>
            (lnk_out_valid && $stable(lnk_out_flit) && $stable(lnk_out_vc)));

    assert_present_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(slow_tick) |-> ($stable(mod_out_valid) && $stable(mod_out_data)));

    assert_block_until_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (!lnk_in_ready && !slow_tick) |=> !lnk_in_ready);
endmodule

bind tdm_router_port tdm_router_port_chk #(
    .FLIT_W(FLIT_W), .SLOTS(SLOTS), .VC_COUNT(VC_COUNT)
) u_chk (.*);

// File: tb/tdm_router_port_bench.sv
`timescale 1ns/1ps
module tdm_router_port_bench;
    localparam int FW = 150;
    localparam int NS = 4;
    localparam int VW = 2;
    localparam int WW = FW * NS;

    // Vector: {single, slot[1:0], vc[1:0], seed[31:0]}
    localparam int NV = 6;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 2'd0, 2'd1, 32'h1111_0001},
        {1'b0, 2'd0, 2'd2, 32'hDEAD_BEEF},
        {1'b1, 2'd0, 2'd3, 32'h0000_0042},
        {1'b1, 2'd2, 2'd0, 32'h1234_5678},
        {1'b1, 2'd3, 2'd1, 32'hCAFE_0003},
        {1'b0, 2'd0, 2'd0, 32'h0BAD_F00D}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_single;
    logic [1:0]    cfg_slot;
    logic          slow_tick;
    logic          mod_in_valid;
    logic          mod_in_ready;
    logic [WW-1:0] mod_in_data;
    logic [VW-1:0] mod_in_vc;
    logic          lnk_out_valid;
    logic          lnk_out_ready;
    logic [FW-1:0] lnk_out_flit;
    logic [VW-1:0] lnk_out_vc;
    logic          lnk_in_valid;
    logic          lnk_in_ready;
    logic [FW-1:0] lnk_in_flit;
    logic [VW-1:0] lnk_in_vc;
    logic          mod_out_valid;
    logic [WW-1:0] mod_out_data;
    logic [VW-1:0] mod_out_vc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tdm_router_port u_tdm_router_port (.*);

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] make_flit(input logic [31:0] seed, input int k);
        return {seed, 8'(k), 14'(seed + 32'(k)), ~seed, seed + 32'(k), seed ^ 32'h5A5A_5A5A};
    endfunction

    function automatic logic [WW-1:0] make_word(input logic [31:0] seed);
        logic [WW-1:0] w;
        for (int k = 0; k < NS; k++) w[k*FW +: FW] = make_flit(seed, k);
        return w;
    endfunction

    task automatic wait_tick();
        while (!slow_tick) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_single = 1'b0; cfg_slot = '0;
        mod_in_valid = 1'b0; mod_in_data = '0; mod_in_vc = '0;
        lnk_out_ready = 1'b1; lnk_in_valid = 1'b0; lnk_in_flit = '0; lnk_in_vc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        chk("R11 lnk_out_valid", WW'(lnk_out_valid), '0);
        chk("R11 mod_out_valid", WW'(mod_out_valid), '0);
        chk("R11 mod_in_ready", WW'(mod_in_ready), '0);
        chk("R11 lnk_in_ready", WW'(lnk_in_ready), WW'(1));

        // R1 strobe cadence
        for (int c = 0; c < 8; c++) begin
            chk("R1 slow_tick", WW'(slow_tick), WW'((c % 4) == 3));
            @(negedge clk);
        end

        // Vector table: R3, R5, R6, R2
        for (int i = 0; i < NV; i++) begin
            logic          sgl;
            logic [1:0]    slt;
            logic [1:0]    vcv;
            logic [WW-1:0] w;
            {sgl, slt, vcv} = VEC[i][36:32];
            w = make_word(VEC[i][31:0]);
            wait_tick();
            cfg_single = sgl; cfg_slot = slt;
            mod_in_valid = 1'b1; mod_in_data = w; mod_in_vc = vcv;
            chk("R6 R2 mod_in_ready on tick", WW'(mod_in_ready), WW'(1));
            for (int k = 0; k < NS; k++) begin
                @(negedge clk);
                if (k == 0) mod_in_valid = 1'b0;
                if (sgl) begin
                    chk("R5 single slot valid", WW'(lnk_out_valid), WW'(k == int'(slt)));
                    if (k == int'(slt)) begin
                        chk("R5 single slot flit", WW'(lnk_out_flit), WW'(w[FW-1:0]));
                        chk("R5 single slot vc", WW'(lnk_out_vc), WW'(vcv));
                    end
                end else begin
                    chk("R3 full valid", WW'(lnk_out_valid), WW'(1));
                    chk("R3 full flit order", WW'(lnk_out_flit), WW'(w[k*FW +: FW]));
                    chk("R3 full vc", WW'(lnk_out_vc), WW'(vcv));
                end
                if (k < NS - 1) chk("R2 no accept mid word", WW'(mod_in_ready), '0);
            end
        end

        // R4 backpressure hold, R2 no accept while stalled
        begin
            logic [WW-1:0] w;
            w = make_word(32'h7777_0707);
            wait_tick();
            cfg_single = 1'b0;
            mod_in_valid = 1'b1; mod_in_data = w; mod_in_vc = 2'd2;
            @(negedge clk) mod_in_valid = 1'b0;
            chk("R4 step0 flit", WW'(lnk_out_flit), WW'(w[0 +: FW]));
            @(negedge clk);
            chk("R4 step1 flit", WW'(lnk_out_flit), WW'(w[FW +: FW]));
            lnk_out_ready = 1'b0;
            repeat (3) begin
                @(negedge clk);
                chk("R4 held valid", WW'(lnk_out_valid), WW'(1));
                chk("R4 held flit", WW'(lnk_out_flit), WW'(w[FW +: FW]));
                if (slow_tick) chk("R2 stalled no accept", WW'(mod_in_ready), '0);
            end
            lnk_out_ready = 1'b1;
            @(negedge clk);
            chk("R4 resume step2", WW'(lnk_out_flit), WW'(w[2*FW +: FW]));
            @(negedge clk);
            chk("R4 resume step3", WW'(lnk_out_flit), WW'(w[3*FW +: FW]));
            @(negedge clk);
            chk("R4 word finished", WW'(lnk_out_valid), '0);
        end

        // R7 R8 R9 full-mode receive
        begin
            logic [WW-1:0] w;
            w = make_word(32'h5150_0001);
            cfg_single = 1'b0;
            wait_tick();
            for (int k = 0; k < NS; k++) begin
                @(negedge clk);
                chk("R9 ready while gathering", WW'(lnk_in_ready), WW'(1));
                lnk_in_valid = 1'b1; lnk_in_flit = w[k*FW +: FW];
                lnk_in_vc = (k == 0) ? 2'd3 : 2'd1;
            end
            @(negedge clk) lnk_in_valid = 1'b0;
            chk("R9 ready low after word", WW'(lnk_in_ready), '0);
            chk("R8 not presented yet", WW'(mod_out_valid), '0);
            wait_tick();
            chk("R9 ready low at tick", WW'(lnk_in_ready), '0);
            @(negedge clk);
            chk("R8 presented after tick", WW'(mod_out_valid), WW'(1));
            chk("R7 word order", mod_out_data, w);
            chk("R7 first flit vc", WW'(mod_out_vc), WW'(3));
            repeat (3) begin
                @(negedge clk);
                chk("R8 held for slow period", WW'(mod_out_valid), WW'(1));
                chk("R9 ready restored", WW'(lnk_in_ready), WW'(1));
            end
            @(negedge clk);
            chk("R8 drops with no new word", WW'(mod_out_valid), '0);
        end

        // R10 single-slot receive
        begin
            logic [FW-1:0] f;
            f = make_flit(32'hABCD_0010, 2);
            cfg_single = 1'b1;
            wait_tick();
            @(negedge clk);
            lnk_in_valid = 1'b1; lnk_in_flit = f; lnk_in_vc = 2'd2;
            @(negedge clk) lnk_in_valid = 1'b0;
            chk("R10 one flit closes word", WW'(lnk_in_ready), '0);
            wait_tick();
            @(negedge clk);
            chk("R10 single valid", WW'(mod_out_valid), WW'(1));
            chk("R10 single data", mod_out_data, WW'(f));
            chk("R10 single vc", WW'(mod_out_vc), WW'(2));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule